// File: doc/BRIEF.md
# Sector-Aligning DMA Read-Modify-Write Engine

This block connects a byte-addressed DMA requester to a storage port that only moves whole 512-byte sectors. A request carries a byte offset, a byte length and a direction. The engine widens the request to the smallest run of whole sectors that covers it and issues one multi-sector command for the data itself.

On a read, the storage port returns the whole widened run. The engine passes on only the requested bytes, in order, and drops the filler before and after them. On a write, any partially covered sector at either end is fetched first into a local two-sector buffer. The engine then writes the whole widened run, taking payload bytes from the DMA side and filler bytes from the buffer, so neighbouring data in those sectors is preserved. A one-cycle done pulse ends a successful request. An error response from storage ends the request at once with a one-cycle error pulse.

Top module: `sector_rmw_dma`

## Requirements
- R1: The main storage command of a request carries sector number `offset >> 9` and a count of `((offset+length-1) >> 9) - (offset >> 9) + 1` sectors. `sc_write` is 1 for a write and 0 for a read.
- R2: A read delivers exactly `length` bytes on `dma_rdata`/`dma_rvalid`, equal to the stored bytes at `offset` .. `offset+length-1`, in ascending order. No head or tail filler byte is delivered.
- R3: A write whose offset and end are both multiples of 512 issues no pre-read, only the single write command. The stored bytes in the range then equal the payload.
- R4: A write with `offset % 512 != 0` first pre-reads the sector that holds the first byte. The stored bytes of that sector below the offset are unchanged after the write.
- R5: A write with `(offset+length) % 512 != 0` pre-reads the sector that holds the last byte. The stored bytes of that sector after the end are unchanged after the write.
- R6: Every pre-read is a read of count 1. When both are needed, the head pre-read comes before the tail pre-read. When head and tail fall in the same sector, one pre-read serves both.
- R7: After reset `req_ready` is 1 and no command is pending. A successful request gives exactly one `xfer_done` pulse after the final storage response. `req_ready` stays 0 while a request is in progress.
- R8: A storage response with `sp_err=1` gives one `xfer_err` pulse and no `xfer_done`. No further storage command is issued for that request. A write whose pre-read fails leaves storage unchanged.
- R9: A request with `length = 0` gives a `xfer_done` pulse and issues no storage command.
- R10: Once `sc_valid` is raised, it and the command fields hold until `sc_ready`. Once `sw_valid` is raised, it and `sw_data` hold until `sw_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFF_W | Byte offset of the request |
| req_length | input | LEN_W | Byte length of the request |
| dma_wdata | input | 8 | Write payload byte |
| dma_wvalid | input | 1 | Payload byte valid |
| dma_wready | output | 1 | Payload byte taken |
| dma_rdata | output | 8 | Read byte to the requester |
| dma_rvalid | output | 1 | Read byte valid (no backpressure) |
| xfer_done | output | 1 | One-cycle pulse, request complete |
| xfer_err | output | 1 | One-cycle pulse, request aborted |
| sc_valid | output | 1 | Storage command valid |
| sc_ready | input | 1 | Storage command accepted |
| sc_write | output | 1 | Storage command direction |
| sc_lba | output | OFF_W-9 | Storage command first sector |
| sc_count | output | LEN_W-7 | Storage command sector count |
| sr_valid | input | 1 | Storage read byte valid |
| sr_data | input | 8 | Storage read byte |
| sw_valid | output | 1 | Storage write byte valid |
| sw_data | output | 8 | Storage write byte |
| sw_ready | input | 1 | Storage write byte accepted |
| sp_valid | input | 1 | Storage command response |
| sp_err | input | 1 | Response reports an error |

## Verification
Writes are tried in each alignment case. The fully aligned case shows that no pre-read is issued. A head-only case and a tail-only case each isolate one merge side. A request that starts and ends inside one sector separates the shared single pre-read from two pre-reads. A request spanning several sectors with both ends partial checks the order of the head and tail pre-reads. Reads at aligned, single-sector and boundary-straddling offsets show that filler is dropped exactly at both ends. Errors are injected on a pre-read, on a write command and on a read command. The case with an error on a pre-read shows that storage is left unchanged. Random reads and writes with random offsets, lengths and handshake stalls are then compared against a byte-level reference memory.

// File: rtl/sector_rmw_pkg.sv
package sector_rmw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PLAN,
    ST_PRE_CMD,
    ST_PRE_DATA,
    ST_PRE_RESP,
    ST_WR_CMD,
    ST_WR_FETCH,
    ST_WR_LOAD,
    ST_WR_SEND,
    ST_WR_RESP,
    ST_RD_CMD,
    ST_RD_DATA,
    ST_RD_RESP
  } eng_state_t;

endpackage

// File: rtl/sector_span_geom.sv
// Combinational geometry of a byte request widened to whole sectors.
module sector_span_geom #(
  parameter int OFF_W  = 32,
  parameter int LEN_W  = 16,
  parameter int SEC_SH = 9,
  localparam int LBA_W  = OFF_W - SEC_SH,
  localparam int CNT_W  = LEN_W - SEC_SH + 2,
  localparam int SPAN_W = CNT_W + SEC_SH
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  output logic [LBA_W-1:0]  first_lba,
  output logic [LBA_W-1:0]  last_lba,
  output logic [CNT_W-1:0]  sec_cnt,
  output logic [SEC_SH-1:0] head_skip,
  output logic [SPAN_W-1:0] span_last,
  output logic              head_part,
  output logic              tail_part,
  output logic              one_sector
);
  logic [SEC_SH-1:0] end_rem;

  assign first_lba  = off[OFF_W-1:SEC_SH];
  assign last_lba   = LBA_W'((off + OFF_W'(len) - OFF_W'(1)) >> SEC_SH);
  assign sec_cnt    = CNT_W'(last_lba - first_lba) + CNT_W'(1);
  assign head_skip  = off[SEC_SH-1:0];
  assign end_rem    = off[SEC_SH-1:0] + len[SEC_SH-1:0];
  assign span_last  = {sec_cnt, {SEC_SH{1'b0}}} - SPAN_W'(1);
  assign head_part  = |head_skip;
  assign tail_part  = |end_rem;
  assign one_sector = (first_lba == last_lba);
endmodule

// File: rtl/sector_buf.sv
// Simple dual-port buffer with registered read, suitable for block RAM.
module sector_buf #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sector_rmw_dma.sv
module sector_rmw_dma
  import sector_rmw_pkg::*;
#(
  parameter int OFF_W     = 32,
  parameter int LEN_W     = 16,
  parameter int SEC_BYTES = 512,
  parameter int BYTE_W    = 8,
  localparam int SEC_SH   = $clog2(SEC_BYTES),
  localparam int LBA_W    = OFF_W - SEC_SH,
  localparam int CNT_W    = LEN_W - SEC_SH + 2,
  localparam int SPAN_W   = CNT_W + SEC_SH,
  localparam int BUF_AW   = SEC_SH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [LEN_W-1:0]  req_length,
  input  logic [BYTE_W-1:0] dma_wdata,
  input  logic              dma_wvalid,
  output logic              dma_wready,
  output logic [BYTE_W-1:0] dma_rdata,
  output logic              dma_rvalid,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic              sc_valid,
  input  logic              sc_ready,
  output logic              sc_write,
  output logic [LBA_W-1:0]  sc_lba,
  output logic [CNT_W-1:0]  sc_count,
  input  logic              sr_valid,
  input  logic [BYTE_W-1:0] sr_data,
  output logic              sw_valid,
  output logic [BYTE_W-1:0] sw_data,
  input  logic              sw_ready,
  input  logic              sp_valid,
  input  logic              sp_err
);

  eng_state_t        state_q;
  logic              wr_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [SPAN_W-1:0] idx_q;
  logic              slot_q;

  logic [LBA_W-1:0]  first_lba, last_lba;
  logic [CNT_W-1:0]  sec_cnt;
  logic [SEC_SH-1:0] head_skip;
  logic [SPAN_W-1:0] span_last;
  logic              head_part, tail_part, one_sector;

  sector_span_geom #(.OFF_W(OFF_W), .LEN_W(LEN_W), .SEC_SH(SEC_SH)) u_geom (
    .off(off_q), .len(len_q),
    .first_lba(first_lba), .last_lba(last_lba), .sec_cnt(sec_cnt),
    .head_skip(head_skip), .span_last(span_last),
    .head_part(head_part), .tail_part(tail_part), .one_sector(one_sector)
  );

  // Position of the current byte inside the widened span.
  logic [SPAN_W-1:0] pay_lo, pay_hi;
  logic              in_pay, in_last, tail_own, rd_slot, sec_end;
  logic [BYTE_W-1:0] buf_q;

  assign pay_lo   = SPAN_W'(head_skip);
  assign pay_hi   = pay_lo + SPAN_W'(len_q);
  assign in_pay   = (idx_q >= pay_lo) && (idx_q < pay_hi);
  assign in_last  = (idx_q[SPAN_W-1:SEC_SH] == (sec_cnt - CNT_W'(1)));
  // The tail sector needs its own slot unless the head pre-read already holds it.
  assign tail_own = tail_part && !(one_sector && head_part);
  assign rd_slot  = in_last && tail_own;
  assign sec_end  = &idx_q[SEC_SH-1:0];

  sector_buf #(.AW(BUF_AW), .DW(BYTE_W)) u_buf (
    .clk   (clk),
    .we    (state_q == ST_PRE_DATA && sr_valid),
    .waddr ({slot_q, idx_q[SEC_SH-1:0]}),
    .wdata (sr_data),
    .raddr ({rd_slot, idx_q[SEC_SH-1:0]}),
    .rdata (buf_q)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign dma_wready = (state_q == ST_WR_FETCH) && in_pay;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      wr_q       <= 1'b0;
      off_q      <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      slot_q     <= 1'b0;
      dma_rdata  <= '0;
      dma_rvalid <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_err   <= 1'b0;
      sc_valid   <= 1'b0;
      sc_write   <= 1'b0;
      sc_lba     <= '0;
      sc_count   <= '0;
      sw_valid   <= 1'b0;
      sw_data    <= '0;
    end else begin
      xfer_done  <= 1'b0;
      xfer_err   <= 1'b0;
      dma_rvalid <= 1'b0;
      if (state_q != ST_IDLE && sp_valid && sp_err) begin
        // Any failed storage command aborts the request.
        state_q  <= ST_IDLE;
        xfer_err <= 1'b1;
        sc_valid <= 1'b0;
        sw_valid <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (req_valid) begin
              wr_q  <= req_write;
              off_q <= req_offset;
              len_q <= req_length;
              idx_q <= '0;
              if (req_length == '0) xfer_done <= 1'b1;
              else                  state_q   <= ST_PLAN;
            end
          end
          ST_PLAN: begin
            sc_valid <= 1'b1;
            if (!wr_q) begin
              sc_write <= 1'b0;
              sc_lba   <= first_lba;
              sc_count <= sec_cnt;
              state_q  <= ST_RD_CMD;
            end else if (head_part) begin
              sc_write <= 1'b0;
              sc_lba   <= first_lba;
              sc_count <= CNT_W'(1);
              slot_q   <= 1'b0;
              state_q  <= ST_PRE_CMD;
            end else if (tail_part) begin
              sc_write <= 1'b0;
              sc_lba   <= last_lba;
              sc_count <= CNT_W'(1);
              slot_q   <= 1'b1;
              state_q  <= ST_PRE_CMD;
            end else begin
              sc_write <= 1'b1;
              sc_lba   <= first_lba;
              sc_count <= sec_cnt;
              state_q  <= ST_WR_CMD;
            end
          end
          ST_PRE_CMD: begin
            if (sc_ready) begin
              sc_valid <= 1'b0;
              idx_q    <= '0;
              state_q  <= ST_PRE_DATA;
            end
          end
          ST_PRE_DATA: begin
            if (sr_valid) begin
              idx_q <= idx_q + SPAN_W'(1);
              if (sec_end) state_q <= ST_PRE_RESP;
            end
          end
          ST_PRE_RESP: begin
            if (sp_valid) begin
              sc_valid <= 1'b1;
              sc_write <= 1'b0;
              if (!slot_q && tail_own) begin
                sc_lba   <= last_lba;
                sc_count <= CNT_W'(1);
                slot_q   <= 1'b1;
                state_q  <= ST_PRE_CMD;
              end else begin
                sc_write <= 1'b1;
                sc_lba   <= first_lba;
                sc_count <= sec_cnt;
                state_q  <= ST_WR_CMD;
              end
            end
          end
          ST_WR_CMD: begin
            if (sc_ready) begin
              sc_valid <= 1'b0;
              idx_q    <= '0;
              state_q  <= ST_WR_FETCH;
            end
          end
          ST_WR_FETCH: begin
            if (in_pay) begin
              if (dma_wvalid) begin
                sw_data  <= dma_wdata;
                sw_valid <= 1'b1;
                state_q  <= ST_WR_SEND;
              end
            end else begin
              state_q <= ST_WR_LOAD;  // buffer read settles this cycle
            end
          end
          ST_WR_LOAD: begin
            sw_data  <= buf_q;
            sw_valid <= 1'b1;
            state_q  <= ST_WR_SEND;
          end
          ST_WR_SEND: begin
            if (sw_ready) begin
              sw_valid <= 1'b0;
              if (idx_q == span_last) begin
                state_q <= ST_WR_RESP;
              end else begin
                idx_q   <= idx_q + SPAN_W'(1);
                state_q <= ST_WR_FETCH;
              end
            end
          end
          ST_RD_CMD: begin
            if (sc_ready) begin
              sc_valid <= 1'b0;
              idx_q    <= '0;
              state_q  <= ST_RD_DATA;
            end
          end
          ST_RD_DATA: begin
            if (sr_valid) begin
              dma_rvalid <= in_pay;
              dma_rdata  <= sr_data;
              if (idx_q == span_last) state_q <= ST_RD_RESP;
              else                    idx_q   <= idx_q + SPAN_W'(1);
            end
          end
          ST_WR_RESP, ST_RD_RESP: begin
            if (sp_valid) begin
              xfer_done <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sector_rmw_dma_chk.sv
module sector_rmw_dma_chk #(
  parameter int LBA_W = 23,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             dma_wready,
  input logic             dma_rvalid,
  input logic             xfer_done,
  input logic             xfer_err,
  input logic             sc_valid,
  input logic             sc_ready,
  input logic             sc_write,
  input logic [LBA_W-1:0] sc_lba,
  input logic [CNT_W-1:0] sc_count,
  input logic             sw_valid,
  input logic             sw_ready,
  input logic [7:0]       sw_data,
  input logic             wr_q
);

  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    sc_valid && !sc_ready |=> sc_valid && $stable(sc_lba) && $stable(sc_count) && $stable(sc_write));

  a_r10_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    sw_valid && !sw_ready |=> sw_valid && $stable(sw_data));

  a_r8_done_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(xfer_done && xfer_err));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (dma_rvalid || dma_wready || sc_valid || sw_valid) |-> !req_ready);

  a_r6_preread_single: assert property (@(posedge clk) disable iff (rst)
    sc_valid && !sc_write && wr_q |-> sc_count == CNT_W'(1));

  a_r1_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    sc_valid |-> sc_count != '0);

  a_r3_wready_on_write: assert property (@(posedge clk) disable iff (rst)
    dma_wready |-> wr_q);

  a_r2_rvalid_on_read: assert property (@(posedge clk) disable iff (rst)
    dma_rvalid |-> !wr_q);

endmodule

bind sector_rmw_dma sector_rmw_dma_chk #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .dma_wready(dma_wready),
  .dma_rvalid(dma_rvalid), .xfer_done(xfer_done), .xfer_err(xfer_err),
  .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_write(sc_write),
  .sc_lba(sc_lba), .sc_count(sc_count), .sw_valid(sw_valid),
  .sw_ready(sw_ready), .sw_data(sw_data), .wr_q(wr_q)
);

// File: tb/sim_sector_rmw_dma.sv
module sim_sector_rmw_dma;
  localparam int MEMB = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [31:0] req_offset = '0;
  logic [15:0] req_length = '0;
  logic [7:0]  dma_wdata;
  logic        dma_wvalid, dma_wready;
  logic [7:0]  dma_rdata;
  logic        dma_rvalid, xfer_done, xfer_err;
  logic        sc_valid, sc_ready, sc_write;
  logic [22:0] sc_lba;
  logic [8:0]  sc_count;
  logic        sr_valid;
  logic [7:0]  sr_data;
  logic        sw_valid, sw_ready;
  logic [7:0]  sw_data;
  logic        sp_valid, sp_err;

  always #2 clk = ~clk;

  sector_rmw_dma u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_length(req_length),
    .dma_wdata(dma_wdata), .dma_wvalid(dma_wvalid), .dma_wready(dma_wready),
    .dma_rdata(dma_rdata), .dma_rvalid(dma_rvalid),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_write(sc_write),
    .sc_lba(sc_lba), .sc_count(sc_count),
    .sr_valid(sr_valid), .sr_data(sr_data),
    .sw_valid(sw_valid), .sw_data(sw_data), .sw_ready(sw_ready),
    .sp_valid(sp_valid), .sp_err(sp_err)
  );

  logic [7:0] smem [MEMB];
  logic [7:0] refm [MEMB];
  logic [7:0] pay  [4096];
  logic [7:0] rdq  [4096];
  int  lg_lba [8];
  int  lg_cnt [8];
  bit  lg_wr  [8];
  int  nlog, inj_at, wp, plen, nrd, ndone, nerr, hold_viol;
  int  checks, failures, cyc;
  bit  finished;

  // Storage port model.
  int  mst, base, total, xfer;
  bit  fail_now, prev_cmd_hold, prev_wr_hold;
  always @(posedge clk) begin
    if (rst) begin
      mst = 0; prev_cmd_hold = 0; prev_wr_hold = 0;
      sc_ready <= 0; sr_valid <= 0; sr_data <= 0; sw_ready <= 0;
      sp_valid <= 0; sp_err <= 0;
    end else begin
      if (prev_cmd_hold && !sc_valid) hold_viol++;
      if (prev_wr_hold && !sw_valid) hold_viol++;
      prev_cmd_hold = sc_valid && !sc_ready;
      prev_wr_hold  = sw_valid && !sw_ready;
      case (mst)
        0: begin
          if (sc_valid && sc_ready) begin
            base = int'(sc_lba) * 512; total = int'(sc_count) * 512; xfer = 0;
            if (nlog < 8) begin
              lg_lba[nlog] = int'(sc_lba); lg_cnt[nlog] = int'(sc_count); lg_wr[nlog] = sc_write;
            end
            fail_now = (nlog == inj_at);
            nlog++;
            sc_ready <= 0;
            mst = sc_write ? 2 : 1;
          end else begin
            sc_ready <= ($urandom % 3) != 0;
          end
        end
        1: begin
          if (xfer == total) begin
            sr_valid <= 0; sp_valid <= 1; sp_err <= fail_now; mst = 3;
          end else if (($urandom % 4) != 0) begin
            sr_valid <= 1; sr_data <= smem[(base + xfer) % MEMB]; xfer++;
          end else begin
            sr_valid <= 0;
          end
        end
        2: begin
          if (sw_valid && sw_ready) begin
            smem[(base + xfer) % MEMB] = sw_data; xfer++;
          end
          if (xfer == total) begin
            sw_ready <= 0; sp_valid <= 1; sp_err <= fail_now; mst = 3;
          end else begin
            sw_ready <= ($urandom % 4) != 0;
          end
        end
        default: begin
          sp_valid <= 0; sp_err <= 0; mst = 0;
        end
      endcase
    end
  end

  // DMA payload source and read sink.
  always @(posedge clk) begin
    if (rst) begin
      dma_wvalid <= 0; dma_wdata <= 0;
    end else begin
      if (dma_wvalid && dma_wready) wp++;
      if (wp < plen && ($urandom % 4) != 0) begin
        dma_wvalid <= 1; dma_wdata <= pay[wp];
      end else begin
        dma_wvalid <= 0;
      end
      if (dma_rvalid) begin
        if (nrd < 4096) rdq[nrd] = dma_rdata;
        nrd++;
      end
      if (xfer_done) ndone++;
      if (xfer_err)  nerr++;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cyc, 190000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input int off, input int len, input int inj);
    int d0, e0, guard, first, last, nsec, npre, mism;
    bit hp, tp, same;
    string tag;
    first = off / 512;
    last  = (len == 0) ? first : (off + len - 1) / 512;
    nsec  = last - first + 1;
    hp    = (off % 512) != 0;
    tp    = ((off + len) % 512) != 0;
    same  = (first == last);
    npre  = wr ? ((hp ? 1 : 0) + ((tp && !(same && hp)) ? 1 : 0)) : 0;
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    @(negedge clk);
    wp = 0; plen = wr ? len : 0; nrd = 0; nlog = 0; inj_at = inj;
    d0 = ndone; e0 = nerr;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = 32'(off); req_length = 16'(len);
    @(posedge clk); #1 req_valid = 0;
    guard = 0;
    while (ndone == d0 && nerr == e0 && guard < 40000) begin
      @(posedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    if (len == 0) begin
      chk(ndone == d0 + 1 && nerr == e0, "R9 zero length done", ndone - d0, 1);
      chk(nlog == 0, "R9 zero length issues no command", nlog, 0);
    end else if (inj >= 0) begin
      chk(nerr == e0 + 1 && ndone == d0, "R8 error pulse without done", nerr - e0, 1);
      chk(nlog == inj + 1, "R8 no command after error", nlog, inj + 1);
      if (wr && inj < npre) begin
        mism = 0;
        for (int i = 0; i < MEMB; i++) if (smem[i] !== refm[i]) mism++;
        chk(mism == 0, "R8 failed pre-read leaves storage unchanged", mism, 0);
      end else begin
        for (int i = 0; i < MEMB; i++) refm[i] = smem[i];
      end
    end else begin
      chk(ndone == d0 + 1 && nerr == e0, "R7 single done pulse", ndone - d0, 1);
      if (wr) begin
        for (int i = 0; i < len; i++) refm[off + i] = pay[i];
        mism = 0;
        for (int i = 0; i < MEMB; i++) if (smem[i] !== refm[i]) mism++;
        tag = hp ? "R4 head merge" : (tp ? "R5 tail merge" : "R3 aligned write");
        chk(mism == 0, tag, mism, 0);
        chk(nlog == npre + 1, "R6 pre-read count", nlog, npre + 1);
        for (int k = 0; k < npre && k < 8; k++)
          chk(!lg_wr[k] && lg_cnt[k] == 1, "R6 pre-read is one-sector read", lg_cnt[k], 1);
        if (hp) chk(lg_lba[0] == first, "R4 head pre-read first", lg_lba[0], first);
        if (tp && !(same && hp) && npre > 0)
          chk(lg_lba[npre - 1] == last, "R5 tail pre-read last", lg_lba[npre - 1], last);
        if (npre < 8)
          chk(lg_wr[npre] && lg_lba[npre] == first && lg_cnt[npre] == nsec,
              "R1 write command geometry", lg_cnt[npre], nsec);
      end else begin
        chk(nrd == len, "R2 read byte count", nrd, len);
        mism = 0;
        for (int i = 0; i < len && i < nrd; i++) if (rdq[i] !== smem[off + i]) mism++;
        chk(mism == 0, "R2 read data", mism, 0);
        chk(nlog == 1 && !lg_wr[0] && lg_lba[0] == first && lg_cnt[0] == nsec,
            "R1 read command geometry", lg_cnt[0], nsec);
      end
    end
  endtask

  initial begin
    int r_off, r_len;
    bit r_wr;
    void'($urandom(32'h5EC7_0A11));
    for (int i = 0; i < MEMB; i++) begin
      smem[i] = 8'($urandom); refm[i] = smem[i];
    end
    nlog = 0; inj_at = -1; wp = 0; plen = 0; nrd = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 reset ready", req_ready, 1);
    chk(sc_valid == 1'b0 && sw_valid == 1'b0, "R7 reset no command", sc_valid, 0);
    chk(xfer_done == 1'b0 && xfer_err == 1'b0, "R7 reset no pulse", xfer_done, 0);

    run_op(1, 1024, 512, -1);   // R3 both ends aligned
    run_op(1, 1000, 24, -1);    // R4 head only
    run_op(1, 2048, 700, -1);   // R5 tail only
    run_op(1, 3000, 10, -1);    // R6 same sector, single pre-read
    run_op(1, 600, 1500, -1);   // R6 head then tail
    run_op(1, 4095, 1, -1);     // single byte at sector end
    run_op(1, 4608, 100, -1);   // aligned head, tail in same sector
    run_op(0, 3000, 10, -1);    // R2 inside one sector
    run_op(0, 0, 512, -1);      // R2 aligned
    run_op(0, 511, 2, -1);      // R2 straddling boundary
    run_op(1, 100, 0, -1);      // R9
    run_op(1, 700, 100, 0);     // R8 error on pre-read
    run_op(1, 5000, 1200, 2);   // R8 error on write command
    run_op(0, 300, 900, 0);     // R8 error on read
    for (int n = 0; n < 16; n++) begin
      r_wr  = 1'($urandom);
      r_len = 1 + ($urandom % 600);
      r_off = $urandom % (MEMB - r_len);
      run_op(r_wr, r_off, r_len, -1);
    end
    chk(hold_viol == 0, "R10 valid held until ready", hold_viol, 0);
    summary();
  end
endmodule